// File: doc/BRIEF.md
# Three-Channel PWM Waveform Generator

This block produces three pulse-width-modulated outputs that are meant to be smoothed by external RC filters into analog waveforms. All three channels share one free-running period counter. The counter counts from 0 up to 255 and then returns to 0, so one PWM period is 256 clock cycles. With a 2.048 MHz clock this gives an 8 kHz sample rate.

Each channel has an active compare register and a set/clear output stage. Its output goes high when the counter returns to 0. It goes low on the cycle the counter equals the channel's compare value. New compare values are loaded only at the period boundary and never in the middle of a period.

The three channels are fed as follows:
- The first channel is fed by a hardware pointer that walks a 32-entry sine table, one entry per period. At the default clock this gives 250 Hz.
- The second channel is fed by a sawtooth stepper. It adds 4 per period and wraps after 64 steps, giving 125 Hz.
- The third channel takes an 8-bit level from a pin. It is captured once per period and sets a DC value.

Top module: `pwm_wave_dac`

## Requirements
- R1: The period counter steps by one each clock from 0 to 255 and then wraps to 0, so every PWM period lasts exactly 256 cycles and each output is high for exactly as many cycles of a period as its compare value.
- R2: Within a period, an output is high on the cycles where the count is below the active compare value and low on all the others. It rises on the cycle the count is 0 and falls on the cycle the count equals the compare value.
- R3: A compare value of 0 keeps the output low for the entire period.
- R4: In the k-th period after reset (k ≥ 1), the sine output uses compare value round(128 + 127·sin(2π·i/32)) with i = (k−1) mod 32. This table is unsigned and centred on 128.
- R5: In the k-th period after reset (k ≥ 1), the ramp output uses compare value 4·((k−1) mod 64). It climbs from 0 to 252 and then restarts at 0.
- R6: The DC output uses the value on `dc_level_i` captured on the last cycle of the previous period, when the count is 255. Changes on `dc_level_i` at any other cycle have no effect on the output.
- R7: While reset is asserted, and for the whole first period after it is released, all three outputs are low and the counter is 0 at release.
- R8: After the sine pointer has used entry 31, it returns to entry 0, so period 33 repeats the sample of period 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dc_level_i | input | 8 | Requested DC duty, captured once per period |
| pwm_sine_o | output | 1 | PWM output carrying the sine waveform |
| pwm_ramp_o | output | 1 | PWM output carrying the sawtooth waveform |
| pwm_dc_o | output | 1 | PWM output carrying the constant level |

## Verification
The bench drives random values on `dc_level_i` on every cycle, not just at the capture point. A design that loaded compare values mid-period would show glitched pulse widths, and one that captured the level on the wrong cycle would show DC widths from the wrong draw.

Directed levels of 0, 1, 128 and 255 target the extremes of the output stage:
- A stage that set the output at wrap regardless of the compare value would emit a stray pulse at 0.
- An off-by-one on the clear event would stretch or shorten every pulse by a cycle.

The run spans more than 64 periods, so both sequencer wraps are exercised. A pointer that failed to return from entry 31, or a ramp that overflowed past 252 instead of restarting, would break the period-by-period sample sequence.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    localparam int unsigned SAMPLE_W   = 8;
    localparam int unsigned SINE_DEPTH = 32;
    localparam int unsigned NUM_CHAN   = 3;

    typedef enum logic [1:0] {
        CH_SINE = 2'd0,
        CH_RAMP = 2'd1,
        CH_DC   = 2'd2
    } chan_e;

    // Quarter-wave symmetric sine, centred at 128, amplitude 127.
    function automatic logic [SAMPLE_W-1:0] sine_sample(input logic [4:0] idx);
        logic [SAMPLE_W-1:0] v;
        unique case (idx)
            5'd0:  v = 8'd128;
            5'd1:  v = 8'd153;
            5'd2:  v = 8'd177;
            5'd3:  v = 8'd199;
            5'd4:  v = 8'd218;
            5'd5:  v = 8'd234;
            5'd6:  v = 8'd245;
            5'd7:  v = 8'd253;
            5'd8:  v = 8'd255;
            5'd9:  v = 8'd253;
            5'd10: v = 8'd245;
            5'd11: v = 8'd234;
            5'd12: v = 8'd218;
            5'd13: v = 8'd199;
            5'd14: v = 8'd177;
            5'd15: v = 8'd153;
            5'd16: v = 8'd128;
            5'd17: v = 8'd103;
            5'd18: v = 8'd79;
            5'd19: v = 8'd57;
            5'd20: v = 8'd38;
            5'd21: v = 8'd22;
            5'd22: v = 8'd11;
            5'd23: v = 8'd3;
            5'd24: v = 8'd1;
            5'd25: v = 8'd3;
            5'd26: v = 8'd11;
            5'd27: v = 8'd22;
            5'd28: v = 8'd38;
            5'd29: v = 8'd57;
            5'd30: v = 8'd79;
            default: v = 8'd103;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int unsigned CNT_MAX = 255,
    localparam int unsigned CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_W'(CNT_MAX)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = (st_q.cnt == CNT_W'(CNT_MAX));

    // R1: counter wraps to zero after its maximum
    p_wrap_to_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_o == '0));

    // R1: counter advances by exactly one otherwise
    p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_o |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/pwm_wave_seq.sv
module pwm_wave_seq
    import pwm_dac_pkg::*;
#(
    parameter int unsigned CNT_MAX     = 255,
    parameter int unsigned RAMP_STEPS  = 64,
    localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1),
    localparam int unsigned PTR_W      = $clog2(SINE_DEPTH),
    localparam int unsigned RAMP_INC   = (CNT_MAX + 1) / RAMP_STEPS,
    localparam int unsigned RAMP_TOP   = CNT_MAX + 1 - RAMP_INC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wrap_i,
    output logic [CNT_W-1:0] sine_cmp_o,
    output logic [CNT_W-1:0] ramp_cmp_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] ramp;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            // pointer wraps modulo the table depth by width
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.ramp == CNT_W'(RAMP_TOP)) begin
                st_d.ramp = '0;
            end else begin
                st_d.ramp = st_q.ramp + CNT_W'(RAMP_INC);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sine_cmp_o = CNT_W'(sine_sample(5'(st_q.ptr)));
    assign ramp_cmp_o = st_q.ramp;

    // R8: pointer returns to entry 0 after the last entry
    p_ptr_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && st_q.ptr == PTR_W'(SINE_DEPTH - 1)) |=> (st_q.ptr == '0));

    // R5: ramp restarts at zero after its top value
    p_ramp_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && st_q.ramp == CNT_W'(RAMP_TOP)) |=> (st_q.ramp == '0));

    // R5: ramp only moves at the period boundary
    p_ramp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(st_q.ramp));

    // R4: pointer only moves at the period boundary
    p_ptr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(st_q.ptr));

endmodule

// File: rtl/pwm_rs_channel.sv
module pwm_rs_channel #(
    parameter int unsigned CNT_MAX = 255,
    localparam int unsigned CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             out;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [CNT_W:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        cnt_next = {1'b0, cnt_i} + 1'b1;
        if (wrap_i) begin
            // period boundary: take the buffered value and set the output
            st_d.cmp = load_i;
            st_d.out = (load_i != '0);
        end else if (cnt_next == {1'b0, st_q.cmp}) begin
            // count is about to reach the compare value: clear
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.out;

    // R2: output is high exactly while the count is below the compare
    p_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwm_o == (cnt_i < st_q.cmp));

    // R3: zero compare never lets the output rise
    p_zero_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cmp == '0) |-> !pwm_o);

    // R6: compare value never changes mid-period
    p_cmp_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(st_q.cmp));

endmodule

// File: rtl/pwm_wave_dac.sv
module pwm_wave_dac
    import pwm_dac_pkg::*;
#(
    parameter int unsigned CNT_MAX    = 255,
    parameter int unsigned RAMP_STEPS = 64,
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [SAMPLE_W-1:0] dc_level_i,
    output logic                pwm_sine_o,
    output logic                pwm_ramp_o,
    output logic                pwm_dc_o
);

    logic [CNT_W-1:0]    cnt;
    logic                wrap;
    logic [CNT_W-1:0]    sine_cmp;
    logic [CNT_W-1:0]    ramp_cmp;
    logic [CNT_W-1:0]    load [NUM_CHAN];
    logic [NUM_CHAN-1:0] pwm;

    pwm_period_ctr #(
        .CNT_MAX (CNT_MAX)
    ) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    pwm_wave_seq #(
        .CNT_MAX    (CNT_MAX),
        .RAMP_STEPS (RAMP_STEPS)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wrap_i     (wrap),
        .sine_cmp_o (sine_cmp),
        .ramp_cmp_o (ramp_cmp)
    );

    assign load[CH_SINE] = sine_cmp;
    assign load[CH_RAMP] = ramp_cmp;
    assign load[CH_DC]   = CNT_W'(dc_level_i);

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        pwm_rs_channel #(
            .CNT_MAX (CNT_MAX)
        ) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cnt_i  (cnt),
            .wrap_i (wrap),
            .load_i (load[g]),
            .pwm_o  (pwm[g])
        );
    end

    assign pwm_sine_o = pwm[CH_SINE];
    assign pwm_ramp_o = pwm[CH_RAMP];
    assign pwm_dc_o   = pwm[CH_DC];

    // R7: every output is low right after reset is released
    p_reset_low_r7: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (pwm == '0));

endmodule

// File: tb/pwm_wave_dac_tb_top.sv
module pwm_wave_dac_tb_top;

    localparam int PERIODS = 70;

    logic       clk;
    logic       rst_n;
    logic [7:0] dc_level;
    logic       pwm_sine, pwm_ramp, pwm_dc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    pwm_wave_dac dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .dc_level_i (dc_level),
        .pwm_sine_o (pwm_sine),
        .pwm_ramp_o (pwm_ramp),
        .pwm_dc_o   (pwm_dc)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic int sine_exp(input int i);
        real x;
        x = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 32.0);
        return $rtoi(x + 0.5);
    endfunction

    function automatic int ramp_exp(input int p);
        return 4 * ((p - 1) % 64);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int exp_cmp [3];
        int next_dc;
        int bad [3];
        int high [3];
        logic [2:0] o;
        void'($urandom(32'd20240607));
        rst_n    = 1'b0;
        dc_level = 8'd0;
        next_dc  = 0;
        repeat (4) @(negedge clk);
        // R7: outputs low while held in reset
        check({pwm_sine, pwm_ramp, pwm_dc} == 3'b000, "R7 reset outputs",
              int'({pwm_sine, pwm_ramp, pwm_dc}), 0);
        rst_n = 1'b1;
        for (int p = 0; p < PERIODS; p++) begin
            if (p == 0) begin
                exp_cmp = '{0, 0, 0};
            end else begin
                exp_cmp[0] = sine_exp((p - 1) % 32);
                exp_cmp[1] = ramp_exp(p);
                exp_cmp[2] = next_dc;
            end
            bad  = '{0, 0, 0};
            high = '{0, 0, 0};
            for (int c = 0; c < 256; c++) begin
                if (c != 0) @(negedge clk);
                o = {pwm_dc, pwm_ramp, pwm_sine};
                for (int ch = 0; ch < 3; ch++) begin
                    if (o[ch] != (c < exp_cmp[ch])) bad[ch]++;
                    if (o[ch]) high[ch]++;
                end
                if (c == 255) begin
                    case (p + 1)
                        1: next_dc = 0;
                        2: next_dc = 255;
                        3: next_dc = 1;
                        4: next_dc = 128;
                        5: next_dc = 0;
                        default: next_dc = int'($urandom_range(255));
                    endcase
                    dc_level = 8'(next_dc);
                end else begin
                    // R6: noise off the capture cycle must be ignored
                    dc_level = 8'($urandom);
                end
            end
            @(negedge clk);
            // R2 shape and R1 width per channel
            check(bad[0] == 0, p == 0 ? "R7 sine first period" :
                  (p == 33 ? "R8 sine pointer wrap" : "R4 R2 sine shape"), bad[0], 0);
            check(bad[1] == 0, (p == 65) ? "R5 ramp wrap" : "R5 R2 ramp shape", bad[1], 0);
            check(bad[2] == 0, exp_cmp[2] == 0 ? "R3 zero duty low" : "R6 R2 dc shape",
                  bad[2], 0);
            check(high[2] == exp_cmp[2], "R1 dc high count", high[2], exp_cmp[2]);
            check(high[0] == exp_cmp[0], "R1 sine high count", high[0], exp_cmp[0]);
        end
        done = 1;
        summary();
        $finish;
    end

endmodule